// File: doc/BRIEF.md
# PCI I/O Target Interface

This block is the bus-facing front end of a multi-function I/O device on a 32-bit multiplexed address/data PCI bus. It watches for the start of each transaction. It captures the address and command, checks the address against a set of 8-byte I/O windows, and claims I/O reads and I/O writes that hit one of them. It then runs one or more data phases and converts each completed phase into per-byte-lane read or write strobes on a simple register port behind it.

The initiator supplies only the starting address. The target counts the address up by one dword for every completed data phase of a burst. Wait states come from the `irdyN`/`trdyNOut` handshake. After the final transfer, the target drives `devselNOut` and `trdyNOut` high for one clock and then releases them. Each window belongs to one function of the device, for example a serial port, a second serial port, a printer port and the printer's configuration registers. The function number and a 3-bit register offset per lane go to the register port.

Top module: `pciIoTarget`

## Requirements
- R1: While reset is held and right after it, `devselNOe`, `trdyNOe` and `adOe` are 0, and `bkRdStb` and `bkWrStb` are all zero.
- R2: An address phase is a clock in which `frameN` is sampled low after being high in the previous clock. The target claims the transaction only if the command on `cbeN` is I/O Read (4'b0010) or I/O Write (4'b0011) and the address hits a window. The claim shows as `devselNOe`=1 and `devselNOut`=0 in the clock after the address phase. For any other command or address, `devselNOe` stays 0.
- R3: Window k covers the byte addresses whose bits [31:3] equal bits [31:3] of base k (bits [32k+31:32k] of `BASES`). When more than one window matches, the lowest k wins. `bkFunc` carries k for the whole transaction.
- R4: A write data phase completes on the edge where `irdyN` and `trdyNOut` are both low. In the next clock, `bkWrStb` equals the inverted `cbeN` of that phase, `bkWrData` equals the AD data of that phase, and lane i's offset is `bkOffs[3i+2:3i]` = {address bit 2, i}.
- R5: In a read data phase, the target pulses `bkRdStb` for one clock with the enabled lanes (the inverted `cbeN`). It then drives `trdyNOut` low with `adOe`=1. Lanes that were not enabled read as 8'h00. The first `trdyNOut` low comes three clocks after the address phase.
- R6: While `irdyN` is high, a data phase does not complete. No extra strobe is issued, and read data on `adOut` stays unchanged while it is driven.
- R7: In a burst, each completed data phase advances the address by 4 bytes. Lane offsets therefore alternate between 0-3 and 4-7, wrapping inside the window, and `bkFunc` does not change.
- R8: The final phase is the one that completes with `frameN` high. In the following clock, `devselNOut` and `trdyNOut` are driven high (output enables 1) for exactly one clock. After that, both output enables are 0.
- R9: A data phase with all four byte enables deasserted (`cbeN`=4'hF) still completes, issues no strobe, and returns 32'h0 on a read.
- R10: `adOe` is 1 only while `trdyNOut` and `devselNOut` are both driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| adIn | input | 32 | Address/data bus as sampled |
| adOut | output | 32 | Read data to drive on the address/data bus |
| adOe | output | 1 | Output enable for `adOut` |
| cbeN | input | 4 | Command in the address phase, active-low byte enables afterwards |
| frameN | input | 1 | Active-low transaction framing from the initiator |
| irdyN | input | 1 | Active-low initiator ready |
| devselNOut | output | 1 | Active-low device select value |
| devselNOe | output | 1 | Output enable for the device select line |
| trdyNOut | output | 1 | Active-low target ready value |
| trdyNOe | output | 1 | Output enable for the target ready line |
| bkFunc | output | FUNC_W | Index of the window that was hit |
| bkOffs | output | 12 | 3-bit register offset per byte lane |
| bkRdStb | output | 4 | One-clock read strobe per byte lane |
| bkWrStb | output | 4 | One-clock write strobe per byte lane |
| bkWrData | output | 32 | Write data, one byte per lane |
| bkRdData | input | 32 | Read data from the register port, one byte per lane |

## Verification
The vector loop sends single-phase transactions that differ in command, window and byte-enable pattern. Misses and non-I/O commands must leave the bus undriven, and each hit must reach the right function and offsets. Bursts that start on the upper half of a window separate a correct dword counter from one that is stuck or wraps into the wrong function. Reads held off by a slow initiator separate a correct handshake from one that strobes again or lets the data change. Phases with no enabled lanes show whether completion is tied to the handshake or to the byte enables.

// File: rtl/pciTgtPkg.sv
package pciTgtPkg;

  localparam int LANES = 4;
  localparam int OFFS_W = 3;
  localparam logic [3:0] CMD_IO_RD = 4'b0010;
  localparam logic [3:0] CMD_IO_WR = 4'b0011;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_XFER,
    ST_RD_WAIT,
    ST_RD_CAP,
    ST_RD_XFER,
    ST_TURN
  } tgtState_e;

  typedef struct packed {
    logic latchAddr;
    logic incAddr;
    logic issueRd;
    logic issueWr;
    logic capRd;
  } dpCtl_t;

endpackage

// File: rtl/pciTgtDecode.sv
module pciTgtDecode #(
  parameter int NUM_FUNC = 4,
  parameter logic [NUM_FUNC*32-1:0] BASES = {32'h0000_2400, 32'h0000_2000, 32'h0000_1008, 32'h0000_1000},
  localparam int FUNC_W = (NUM_FUNC > 1) ? $clog2(NUM_FUNC) : 1
) (
  input  logic [31:0]       addr,
  output logic              hit,
  output logic [FUNC_W-1:0] func
);

  logic [NUM_FUNC-1:0] match;

  // one comparator per window on address bits [31:3]
  generate
    for (genvar k = 0; k < NUM_FUNC; k++) begin : gWin
      assign match[k] = (addr[31:3] == BASES[32*k+3 +: 29]);
    end
  endgenerate

  // lowest window index wins on overlap
  always_comb begin
    hit = |match;
    func = '0;
    for (int k = NUM_FUNC - 1; k >= 0; k--) begin
      if (match[k]) func = FUNC_W'(k);
    end
  end

endmodule

// File: rtl/pciTgtDpath.sv
module pciTgtDpath
  import pciTgtPkg::*;
#(
  parameter int NUM_FUNC = 4,
  parameter logic [NUM_FUNC*32-1:0] BASES = {32'h0000_2400, 32'h0000_2000, 32'h0000_1008, 32'h0000_1000},
  localparam int FUNC_W = (NUM_FUNC > 1) ? $clog2(NUM_FUNC) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [31:0]             adIn,
  input  logic [LANES-1:0]        cbeN,
  input  dpCtl_t                  ctl,
  output logic                    hit,
  output logic [FUNC_W-1:0]       bkFunc,
  output logic [LANES*OFFS_W-1:0] bkOffs,
  output logic [LANES-1:0]        bkRdStb,
  output logic [LANES-1:0]        bkWrStb,
  output logic [8*LANES-1:0]      bkWrData,
  input  logic [8*LANES-1:0]      bkRdData,
  output logic [8*LANES-1:0]      adOut
);

  logic [FUNC_W-1:0] decFunc;
  logic [31:2]       addrQ;
  logic              offHiQ;

  pciTgtDecode #(.NUM_FUNC(NUM_FUNC), .BASES(BASES)) uDecode (
    .addr(adIn),
    .hit (hit),
    .func(decFunc)
  );

  // address capture and dword counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      bkFunc <= '0;
    end else if (ctl.latchAddr) begin
      addrQ  <= adIn[31:2];
      bkFunc <= decFunc;
    end else if (ctl.incAddr) begin
      addrQ  <= addrQ + 30'd1;
    end
  end

  // one-clock lane strobes toward the register port
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bkRdStb  <= '0;
      bkWrStb  <= '0;
      bkWrData <= '0;
      offHiQ   <= 1'b0;
    end else begin
      bkRdStb <= ctl.issueRd ? ~cbeN : '0;
      bkWrStb <= ctl.issueWr ? ~cbeN : '0;
      if (ctl.issueWr) bkWrData <= adIn;
      if (ctl.issueRd || ctl.issueWr) offHiQ <= addrQ[2];
    end
  end

  generate
    for (genvar i = 0; i < LANES; i++) begin : gLane
      assign bkOffs[OFFS_W*i +: OFFS_W] = {offHiQ, 2'(i)};

      always_ff @(posedge clk) begin
        if (!rstN) begin
          adOut[8*i +: 8] <= '0;
        end else if (ctl.capRd) begin
          adOut[8*i +: 8] <= bkRdStb[i] ? bkRdData[8*i +: 8] : 8'h00;
        end
      end
    end
  endgenerate

  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (|bkRdStb) |=> (bkRdStb == '0)); // R5
  AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !((|bkRdStb) && (|bkWrStb))); // R4
  AST_FUNC_HELD: assert property (@(posedge clk) disable iff (!rstN)
    ctl.incAddr |=> $stable(bkFunc)); // R7

endmodule

// File: rtl/pciTgtCtrl.sv
module pciTgtCtrl
  import pciTgtPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameN,
  input  logic       irdyN,
  input  logic [3:0] cbeN,
  input  logic       hit,
  output dpCtl_t     ctl,
  output logic       devselNOut,
  output logic       devselNOe,
  output logic       trdyNOut,
  output logic       trdyNOe,
  output logic       adOe
);

  tgtState_e state, nextState;
  logic      prevFrameN;
  logic      addrPhase;
  logic      ioCmd;
  logic      busy;

  assign addrPhase = !frameN && prevFrameN;
  assign ioCmd     = (cbeN == CMD_IO_RD) || (cbeN == CMD_IO_WR);
  assign busy      = !((state == ST_IDLE) || (state == ST_TURN));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      prevFrameN <= 1'b1;
    end else begin
      state      <= nextState;
      prevFrameN <= frameN;
    end
  end

  always_comb begin
    nextState = state;
    ctl       = '0;
    unique case (state)
      ST_IDLE, ST_TURN: begin
        nextState = ST_IDLE;
        if (addrPhase && hit && ioCmd) begin
          ctl.latchAddr = 1'b1;
          nextState = (cbeN == CMD_IO_RD) ? ST_RD_WAIT : ST_WR_XFER;
        end
      end
      ST_WR_XFER: begin
        if (!irdyN) begin
          ctl.issueWr = 1'b1;
          if (frameN) nextState = ST_TURN;
          else        ctl.incAddr = 1'b1;
        end
      end
      ST_RD_WAIT: begin
        ctl.issueRd = 1'b1;
        nextState   = ST_RD_CAP;
      end
      ST_RD_CAP: begin
        ctl.capRd = 1'b1;
        nextState = ST_RD_XFER;
      end
      ST_RD_XFER: begin
        if (!irdyN) begin
          if (frameN) begin
            nextState = ST_TURN;
          end else begin
            ctl.incAddr = 1'b1;
            nextState   = ST_RD_WAIT;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign devselNOe  = (state != ST_IDLE);
  assign trdyNOe    = (state != ST_IDLE);
  assign devselNOut = !busy;
  assign trdyNOut   = !((state == ST_WR_XFER) || (state == ST_RD_XFER));
  assign adOe       = (state == ST_RD_XFER);

  AST_CLAIM_HIT: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && addrPhase && hit && ioCmd) |=> (devselNOe && !devselNOut)); // R2
  AST_NO_CLAIM: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && addrPhase && !(hit && ioCmd)) |=> !devselNOe); // R2
  AST_TURN_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (devselNOe && devselNOut) |=> !(devselNOe && devselNOut)); // R8
  AST_TURN_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !irdyN && !trdyNOut && frameN) |=> (devselNOe && devselNOut && trdyNOut)); // R8

endmodule

// File: rtl/pciIoTarget.sv
module pciIoTarget
  import pciTgtPkg::*;
#(
  parameter int NUM_FUNC = 4,
  parameter logic [NUM_FUNC*32-1:0] BASES = {32'h0000_2400, 32'h0000_2000, 32'h0000_1008, 32'h0000_1000},
  localparam int FUNC_W = (NUM_FUNC > 1) ? $clog2(NUM_FUNC) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [31:0]             adIn,
  output logic [31:0]             adOut,
  output logic                    adOe,
  input  logic [3:0]              cbeN,
  input  logic                    frameN,
  input  logic                    irdyN,
  output logic                    devselNOut,
  output logic                    devselNOe,
  output logic                    trdyNOut,
  output logic                    trdyNOe,
  output logic [FUNC_W-1:0]       bkFunc,
  output logic [LANES*OFFS_W-1:0] bkOffs,
  output logic [3:0]              bkRdStb,
  output logic [3:0]              bkWrStb,
  output logic [31:0]             bkWrData,
  input  logic [31:0]             bkRdData
);

  dpCtl_t ctl;
  logic   hit;

  pciTgtCtrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .frameN    (frameN),
    .irdyN     (irdyN),
    .cbeN      (cbeN),
    .hit       (hit),
    .ctl       (ctl),
    .devselNOut(devselNOut),
    .devselNOe (devselNOe),
    .trdyNOut  (trdyNOut),
    .trdyNOe   (trdyNOe),
    .adOe      (adOe)
  );

  pciTgtDpath #(.NUM_FUNC(NUM_FUNC), .BASES(BASES)) uDpath (
    .clk     (clk),
    .rstN    (rstN),
    .adIn    (adIn),
    .cbeN    (cbeN),
    .ctl     (ctl),
    .hit     (hit),
    .bkFunc  (bkFunc),
    .bkOffs  (bkOffs),
    .bkRdStb (bkRdStb),
    .bkWrStb (bkWrStb),
    .bkWrData(bkWrData),
    .bkRdData(bkRdData),
    .adOut   (adOut)
  );

  AST_AD_WITH_TRDY: assert property (@(posedge clk) disable iff (!rstN)
    adOe |-> (!trdyNOut && !devselNOut)); // R10
  AST_WR_ON_XFER: assert property (@(posedge clk) disable iff (!rstN)
    (|bkWrStb) |-> $past(!irdyN && !trdyNOut)); // R4
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (adOe && $past(adOe && irdyN)) |-> $stable(adOut)); // R6

endmodule

// File: tb/tb_pciIoTarget.sv
`timescale 1ns/1ps
module tb_pciIoTarget;

  localparam logic [3:0] IO_RD = 4'b0010;
  localparam logic [3:0] IO_WR = 4'b0011;
  localparam logic [31:0] TB_BASE [4] = '{32'h0000_1000, 32'h0000_1008, 32'h0000_2000, 32'h0000_2400};

  // {cmd, addr, byte enables (active high), write data}
  localparam logic [71:0] VEC [10] = '{
    {IO_WR, 32'h0000_1000, 4'hF, 32'h1122_3344},
    {IO_WR, 32'h0000_1004, 4'h5, 32'hAABB_CCDD},
    {IO_RD, 32'h0000_1004, 4'hF, 32'h0000_0000},
    {IO_WR, 32'h0000_2404, 4'h8, 32'h5A00_0000},
    {IO_RD, 32'h0000_2404, 4'hA, 32'h0000_0000},
    {IO_WR, 32'h0000_1010, 4'hF, 32'hDEAD_BEEF},
    {4'h6,  32'h0000_1000, 4'hF, 32'h0000_0000},
    {IO_RD, 32'h0000_1008, 4'h3, 32'h0000_0000},
    {IO_WR, 32'h0000_2000, 4'h2, 32'h0000_EE00},
    {IO_RD, 32'h0000_2000, 4'hF, 32'h0000_0000}
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] adIn, adOut, bkWrData, bkRdData;
  logic        adOe, frameN, irdyN, devselNOut, devselNOe, trdyNOut, trdyNOe;
  logic [3:0]  cbeN, bkRdStb, bkWrStb;
  logic [1:0]  bkFunc;
  logic [11:0] bkOffs;

  always #2.5 clk = ~clk;

  pciIoTarget #(
    .NUM_FUNC(4),
    .BASES({32'h0000_2400, 32'h0000_2000, 32'h0000_1008, 32'h0000_1000})
  ) dut (
    .clk(clk), .rstN(rstN), .adIn(adIn), .adOut(adOut), .adOe(adOe), .cbeN(cbeN),
    .frameN(frameN), .irdyN(irdyN), .devselNOut(devselNOut), .devselNOe(devselNOe),
    .trdyNOut(trdyNOut), .trdyNOe(trdyNOe), .bkFunc(bkFunc), .bkOffs(bkOffs),
    .bkRdStb(bkRdStb), .bkWrStb(bkWrStb), .bkWrData(bkWrData), .bkRdData(bkRdData)
  );

  // register-port model
  logic [7:0] tbMem  [4][8];
  logic [7:0] expMem [4][8];
  int wrStbCyc = 0;
  int rdStbCyc = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int f = 0; f < 4; f++)
        for (int o = 0; o < 8; o++) tbMem[f][o] <= 8'(8'h40 + f * 16 + o);
    end else begin
      for (int i = 0; i < 4; i++)
        if (bkWrStb[i]) tbMem[bkFunc][bkOffs[3*i +: 3]] <= bkWrData[8*i +: 8];
      if (|bkWrStb) wrStbCyc <= wrStbCyc + 1;
      if (|bkRdStb) rdStbCyc <= rdStbCyc + 1;
    end
  end

  always_comb begin
    for (int i = 0; i < 4; i++) bkRdData[8*i +: 8] = tbMem[bkFunc][bkOffs[3*i +: 3]];
  end

  int total = 0;
  int bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic bit tbDecode(input logic [31:0] a, output int f);
    f = 0;
    for (int k = 3; k >= 0; k--) if (a[31:3] == TB_BASE[k][31:3]) begin f = k; end
    for (int k = 0; k < 4; k++) if (a[31:3] == TB_BASE[k][31:3]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [31:0] expRead(input int f, input logic hi, input logic [3:0] be);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[8*i +: 8] = be[i] ? expMem[f][{hi, 2'(i)}] : 8'h00;
    return r;
  endfunction

  function automatic void expWrite(input int f, input logic hi, input logic [3:0] be, input logic [31:0] d);
    for (int i = 0; i < 4; i++) if (be[i]) expMem[f][{hi, 2'(i)}] = d[8*i +: 8];
  endfunction

  function automatic int memDiff();
    int n = 0;
    for (int f = 0; f < 4; f++)
      for (int o = 0; o < 8; o++) if (tbMem[f][o] !== expMem[f][o]) n++;
    return n;
  endfunction

  // bus initiator model
  logic [31:0] wdBuf [4];
  logic [3:0]  beBuf [4];
  logic [31:0] rdBuf [4];
  bit gotClaim, turnOk, adOk, xferOk, holdOk;

  task automatic busXfer(input logic [3:0] cmd, input logic [31:0] addr, input int n, input int waits);
    logic [31:0] held;
    bit heldValid;
    int guard;
    @(negedge clk);
    frameN = 1'b0; irdyN = 1'b1; adIn = addr; cbeN = cmd;
    @(negedge clk);
    gotClaim = devselNOe && !devselNOut;
    adOk = 1; turnOk = 1; xferOk = 1; holdOk = 1;
    if (!gotClaim) begin
      cbeN = ~beBuf[0]; adIn = wdBuf[0]; irdyN = 1'b0; frameN = 1'b1;
      @(negedge clk);
      irdyN = 1'b1;
      if (devselNOe || trdyNOe || adOe) turnOk = 0;
      @(negedge clk);
      if (devselNOe || trdyNOe || adOe) turnOk = 0;
      return;
    end
    for (int p = 0; p < n; p++) begin
      cbeN = ~beBuf[p]; adIn = wdBuf[p];
      heldValid = 0;
      for (int w = 0; w < waits; w++) begin
        irdyN = 1'b1; frameN = 1'b0;
        @(negedge clk);
        if (adOe && trdyNOut) adOk = 0;
        if (adOe) begin
          if (heldValid && adOut !== held) holdOk = 0;
          held = adOut; heldValid = 1;
        end
      end
      irdyN = 1'b0; frameN = (p == n - 1);
      guard = 0;
      while (trdyNOut && guard < 20) begin
        if (adOe) adOk = 0;
        @(negedge clk);
        guard++;
      end
      if (guard >= 20) xferOk = 0;
      rdBuf[p] = adOut;
      if (cmd == IO_RD && !adOe) adOk = 0;
      if (heldValid && adOut !== held) holdOk = 0;
      @(negedge clk);
    end
    irdyN = 1'b1; frameN = 1'b1;
    turnOk = devselNOe && devselNOut && trdyNOe && trdyNOut && !adOe;
    @(negedge clk);
    if (devselNOe || trdyNOe) turnOk = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int f, w0, r0;
    bit h;
    logic [31:0] e;
    for (int ff = 0; ff < 4; ff++)
      for (int o = 0; o < 8; o++) expMem[ff][o] = 8'(8'h40 + ff * 16 + o);
    rstN = 1'b0; frameN = 1'b1; irdyN = 1'b1; adIn = '0; cbeN = 4'hF;
    repeat (4) @(negedge clk);
    chk(!devselNOe && !trdyNOe && !adOe, "R1", "enables in reset", {devselNOe, trdyNOe, adOe}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!devselNOe && !trdyNOe && !adOe && bkRdStb == 0 && bkWrStb == 0, "R1", "after reset",
        {bkRdStb, bkWrStb, 1'b0, devselNOe, trdyNOe, adOe}, 0);

    // vector table, single data phase each
    for (int v = 0; v < 10; v++) begin
      logic [3:0] cmd; logic [31:0] a; logic [3:0] be; logic [31:0] d;
      bit expClaim;
      {cmd, a, be, d} = VEC[v];
      h = tbDecode(a, f);
      expClaim = h && (cmd == IO_RD || cmd == IO_WR);
      wdBuf[0] = d; beBuf[0] = be;
      w0 = wrStbCyc; r0 = rdStbCyc;
      busXfer(cmd, a, 1, 0);
      chk(gotClaim == expClaim, "R2", $sformatf("claim vec %0d", v), 32'(gotClaim), 32'(expClaim));
      chk(turnOk, "R8", $sformatf("release vec %0d", v), 32'(turnOk), 1);
      if (!expClaim) begin
        chk(wrStbCyc == w0 && rdStbCyc == r0, "R2", "no strobe on ignored cycle",
            32'(wrStbCyc - w0 + rdStbCyc - r0), 0);
      end else if (cmd == IO_WR) begin
        expWrite(f, a[2], be, d);
        chk(memDiff() == 0, "R4", $sformatf("write lanes vec %0d (R3 window)", v), 32'(memDiff()), 0);
        chk(wrStbCyc - w0 == 1, "R4", "one write strobe", 32'(wrStbCyc - w0), 1);
      end else begin
        e = expRead(f, a[2], be);
        chk(rdBuf[0] === e, "R5", $sformatf("read data vec %0d (R3 window)", v), rdBuf[0], e);
        chk(adOk, "R10", "AD drive only with TRDY", 32'(adOk), 1);
      end
    end

    // R5 claim-to-data latency
    @(negedge clk);
    frameN = 1'b0; adIn = 32'h0000_1000; cbeN = IO_RD;
    @(negedge clk);
    cbeN = 4'h0; irdyN = 1'b0; frameN = 1'b1;
    @(negedge clk);
    chk(trdyNOut, "R5", "TRDY high 2 clocks after address", 32'(trdyNOut), 1);
    @(negedge clk);
    chk(!trdyNOut && adOe, "R5", "TRDY low 3 clocks after address", {trdyNOut, adOe}, 32'h1);
    @(negedge clk);
    irdyN = 1'b1;
    @(negedge clk);

    // R7 burst write wrapping inside the window
    wdBuf[0] = 32'hA0A1_A2A3; beBuf[0] = 4'hF;
    wdBuf[1] = 32'hB0B1_B2B3; beBuf[1] = 4'hF;
    wdBuf[2] = 32'hC0C1_C2C3; beBuf[2] = 4'h3;
    w0 = wrStbCyc;
    busXfer(IO_WR, 32'h0000_1004, 3, 0);
    expWrite(0, 1'b1, 4'hF, wdBuf[0]);
    expWrite(0, 1'b0, 4'hF, wdBuf[1]);
    expWrite(0, 1'b1, 4'h3, wdBuf[2]);
    chk(memDiff() == 0, "R7", "burst write wraps offsets", 32'(memDiff()), 0);
    chk(wrStbCyc - w0 == 3, "R7", "burst write strobes", 32'(wrStbCyc - w0), 3);
    chk(turnOk, "R8", "release after burst write", 32'(turnOk), 1);

    // R6 burst read with initiator wait states
    beBuf[0] = 4'hF; beBuf[1] = 4'hC; wdBuf[0] = 0; wdBuf[1] = 0;
    r0 = rdStbCyc;
    busXfer(IO_RD, 32'h0000_2000, 2, 4);
    e = expRead(2, 1'b0, 4'hF);
    chk(rdBuf[0] === e, "R7", "burst read phase 0", rdBuf[0], e);
    e = expRead(2, 1'b1, 4'hC);
    chk(rdBuf[1] === e, "R7", "burst read phase 1", rdBuf[1], e);
    chk(rdStbCyc - r0 == 2, "R6", "no extra read strobe in waits", 32'(rdStbCyc - r0), 2);
    chk(holdOk, "R6", "read data held during waits", 32'(holdOk), 1);
    chk(adOk, "R10", "AD drive with TRDY in burst", 32'(adOk), 1);

    // R6 write held off by initiator
    wdBuf[0] = 32'h7788_99AA; beBuf[0] = 4'h1;
    w0 = wrStbCyc;
    busXfer(IO_WR, 32'h0000_2400, 1, 3);
    expWrite(3, 1'b0, 4'h1, wdBuf[0]);
    chk(wrStbCyc - w0 == 1, "R6", "single strobe after write waits", 32'(wrStbCyc - w0), 1);
    chk(memDiff() == 0, "R6", "write after waits", 32'(memDiff()), 0);

    // R9 empty byte enables
    wdBuf[0] = 32'hFFFF_FFFF; beBuf[0] = 4'h0;
    w0 = wrStbCyc;
    busXfer(IO_WR, 32'h0000_1008, 1, 0);
    chk(xferOk && turnOk, "R9", "empty write completes", {xferOk, turnOk}, 32'h3);
    chk(wrStbCyc == w0 && memDiff() == 0, "R9", "empty write has no effect", 32'(wrStbCyc - w0), 0);
    r0 = rdStbCyc;
    busXfer(IO_RD, 32'h0000_1008, 1, 0);
    chk(rdBuf[0] === 32'h0 && rdStbCyc == r0, "R9", "empty read returns zero", rdBuf[0], 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule